// File: doc/BRIEF.md
# Byte-Wide Accumulator Instruction Executor

This block is a small multi-cycle processor core that runs a compact instruction set over an 8-bit accumulator. It fetches one-byte opcodes, plus up to two operand bytes, from a byte-wide synchronous memory. It then executes loads, adds and stores on accumulator A, and stores of a second accumulator B, which is read-only to the program. Four address forms are supported:

- no operand (inherent);
- an immediate data byte;
- a one-byte address in the lowest 256-byte page (direct);
- a full two-byte address sent most significant byte first (extended).

The core is used as a tiny sequencer. At reset the host supplies a start address and a preset value for B. The core then runs until it meets the stop opcode or an opcode it does not know. After that it holds its halt output and stays silent on the memory port until the next reset. A, B, the program counter and the carry bit are driven out on plain status pins.

The memory port is not a stream. It has one address, a read strobe and a write strobe. Read data must be valid on the cycle after the read strobe. There is no back-pressure: the memory must accept every access in the cycle it is issued. The core never reads and writes in the same cycle.

Top module: `acc8_core`

## Requirements
- R1: While reset is high and right after it, pc equals start_addr, acc_a is 0x00, carry is 0, acc_b equals b_preset, and halt and illegal are 0. B never changes afterwards.
- R2: Opcode 0x87 sets A to 0x00 and opcode 0x42 adds one to A, wrapping 0xFF to 0x00. Each is one byte long and takes 3 cycles from fetch to the next fetch.
- R3: Opcode 0x86 loads A with the byte after the opcode, and opcode 0x8B adds that byte to A. Each is two bytes long, takes 4 cycles and performs no data-memory access.
- R4: Opcodes 0x96 (load A), 0x9B (add to A) and 0x97 (store A) use address 0x00 concatenated with the operand byte. Load and add take 5 cycles; store takes 4.
- R5: Opcodes 0xB6 (load A), 0xAB (add to A) and 0xF7 (store B) take a 16-bit address from two operand bytes, the byte at the lower address being the high byte. Load and add take 6 cycles; store takes 5.
- R6: An add writes the low 8 bits of A plus the operand into A and sets carry to the bit-8 carry out. Clear, increment, load and store leave carry unchanged.
- R7: Each fetch cycle advances pc by one. The next opcode is fetched from the address directly after the last byte of the previous instruction.
- R8: Opcode 0x3F raises halt 3 cycles after its fetch, with pc one past the opcode. Halt then stays high, and mem_re, mem_we and pc stay quiet until reset.
- R9: Any other opcode raises illegal and halt 2 cycles after its fetch, with pc one past the opcode. A and carry are left unchanged.
- R10: Read data is taken one cycle after mem_re. A store drives mem_we for exactly one cycle with the address and data. mem_re and mem_we are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 16 | Program counter value loaded during reset |
| b_preset | input | 8 | Accumulator B value loaded during reset |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_re | output | 1 | Read strobe; data is due on the next cycle |
| mem_rdata | input | 8 | Read data, one cycle after mem_re |
| halt | output | 1 | Core has stopped; sticky until reset |
| illegal | output | 1 | Stop was caused by an unknown opcode |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| pc | output | 16 | Program counter |
| carry | output | 1 | Carry bit |

## Verification
Two functions meet head to head when a store rewrites the opcode that comes right after it. The write edge that ends the store is immediately followed by the fetch read of that same byte, so the fetch must see the new value. The bench provokes this by presetting B to the stop opcode and storing it over an unknown opcode. The run is judged correct only if the core halts with illegal low and pc one past the rewritten byte. A second meeting point is an add whose sum wraps past 0xFF: the wrapped result and the carry set must appear together in the same execute cycle. Both cases are compared against the bench's instruction-level model at every instruction boundary.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int PAGE_W = ADDR_W - DATA_W;

  localparam logic [DATA_W-1:0] OPC_CLRA    = 8'h87;
  localparam logic [DATA_W-1:0] OPC_INCA    = 8'h42;
  localparam logic [DATA_W-1:0] OPC_STOP    = 8'h3F;
  localparam logic [DATA_W-1:0] OPC_LDA_IMM = 8'h86;
  localparam logic [DATA_W-1:0] OPC_ADD_IMM = 8'h8B;
  localparam logic [DATA_W-1:0] OPC_LDA_DIR = 8'h96;
  localparam logic [DATA_W-1:0] OPC_ADD_DIR = 8'h9B;
  localparam logic [DATA_W-1:0] OPC_STA_DIR = 8'h97;
  localparam logic [DATA_W-1:0] OPC_LDA_EXT = 8'hB6;
  localparam logic [DATA_W-1:0] OPC_ADD_EXT = 8'hAB;
  localparam logic [DATA_W-1:0] OPC_STB_EXT = 8'hF7;

  typedef enum logic [2:0] {
    K_NONE, K_CLR, K_INC, K_STOP, K_LOAD, K_ADD, K_STA, K_STB
  } kind_t;

  typedef enum logic [1:0] {
    AM_INH, AM_IMM, AM_DIR, AM_EXT
  } amode_t;

  typedef struct packed {
    logic   legal;
    kind_t  kind;
    amode_t mode;
  } dec_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_OPND1, ST_OPND2,
    ST_DATA, ST_EXEC, ST_WB, ST_HALT
  } state_t;

  function automatic logic kind_reads(kind_t k);
    return (k == K_LOAD) || (k == K_ADD);
  endfunction

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [DATA_W-1:0] opcode,
  output dec_t              dec
);

  always_comb begin
    dec.legal = 1'b1;
    dec.kind  = K_NONE;
    dec.mode  = AM_INH;
    unique case (opcode)
      OPC_CLRA:    dec.kind = K_CLR;
      OPC_INCA:    dec.kind = K_INC;
      OPC_STOP:    dec.kind = K_STOP;
      OPC_LDA_IMM: begin dec.kind = K_LOAD; dec.mode = AM_IMM; end
      OPC_ADD_IMM: begin dec.kind = K_ADD;  dec.mode = AM_IMM; end
      OPC_LDA_DIR: begin dec.kind = K_LOAD; dec.mode = AM_DIR; end
      OPC_ADD_DIR: begin dec.kind = K_ADD;  dec.mode = AM_DIR; end
      OPC_STA_DIR: begin dec.kind = K_STA;  dec.mode = AM_DIR; end
      OPC_LDA_EXT: begin dec.kind = K_LOAD; dec.mode = AM_EXT; end
      OPC_ADD_EXT: begin dec.kind = K_ADD;  dec.mode = AM_EXT; end
      OPC_STB_EXT: begin dec.kind = K_STB;  dec.mode = AM_EXT; end
      default:     dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  kind_t        kind,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] opnd,
  input  logic         carry_in,
  output logic [W-1:0] a_out,
  output logic         carry_out
);

  logic [W:0] sum;

  always_comb begin
    sum       = {1'b0, a_in} + {1'b0, opnd};
    a_out     = a_in;
    carry_out = carry_in;
    unique case (kind)
      K_CLR:  a_out = '0;
      K_INC:  a_out = a_in + {{(W-1){1'b0}}, 1'b1};
      K_LOAD: a_out = opnd;
      K_ADD: begin
        a_out     = sum[W-1:0];
        carry_out = sum[W];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] b_preset,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halt,
  output logic              illegal,
  output logic [DATA_W-1:0] acc_a,
  output logic [DATA_W-1:0] acc_b,
  output logic [ADDR_W-1:0] pc,
  output logic              carry
);

  localparam logic [PAGE_W-1:0] ZERO_PAGE = '0;
  localparam logic [ADDR_W-1:0] PC_STEP   = {{(ADDR_W-1){1'b0}}, 1'b1};

  state_t              state_q, state_d;
  logic [ADDR_W-1:0]   pc_q, pc_d;
  logic [DATA_W-1:0]   a_q, a_d;
  logic [DATA_W-1:0]   b_q;
  logic                c_q, c_d;
  dec_t                dec_q, dec_d, dec_w;
  logic [DATA_W-1:0]   hi_q, hi_d;
  logic [DATA_W-1:0]   opnd_q, opnd_d;
  logic [ADDR_W-1:0]   ea_q, ea_d;
  logic                halt_q, halt_d;
  logic                ill_q, ill_d;
  logic [DATA_W-1:0]   alu_a;
  logic                alu_c;

  acc8_decode u_decode (
    .opcode (mem_rdata),
    .dec    (dec_w)
  );

  acc8_alu #(.W(DATA_W)) u_alu (
    .kind      (dec_q.kind),
    .a_in      (a_q),
    .opnd      (opnd_q),
    .carry_in  (c_q),
    .a_out     (alu_a),
    .carry_out (alu_c)
  );

  // Sequencer: one memory access at most per state.
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    a_d       = a_q;
    c_d       = c_q;
    dec_d     = dec_q;
    hi_d      = hi_q;
    opnd_d    = opnd_q;
    ea_d      = ea_q;
    halt_d    = halt_q;
    ill_d     = ill_q;
    mem_addr  = '0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_FETCH: begin
        mem_addr = pc_q;
        mem_re   = 1'b1;
        pc_d     = pc_q + PC_STEP;
        state_d  = ST_DECODE;
      end
      ST_DECODE: begin
        dec_d = dec_w;
        if (!dec_w.legal) begin
          halt_d  = 1'b1;
          ill_d   = 1'b1;
          state_d = ST_HALT;
        end else if (dec_w.mode == AM_INH) begin
          state_d = ST_EXEC;
        end else begin
          mem_addr = pc_q;
          mem_re   = 1'b1;
          pc_d     = pc_q + PC_STEP;
          state_d  = ST_OPND1;
        end
      end
      ST_OPND1: begin
        hi_d   = mem_rdata;
        opnd_d = mem_rdata;
        ea_d   = {ZERO_PAGE, mem_rdata};
        if (dec_q.mode == AM_IMM) begin
          state_d = ST_EXEC;
        end else if (dec_q.mode == AM_EXT) begin
          mem_addr = pc_q;
          mem_re   = 1'b1;
          pc_d     = pc_q + PC_STEP;
          state_d  = ST_OPND2;
        end else if (kind_reads(dec_q.kind)) begin
          mem_addr = {ZERO_PAGE, mem_rdata};
          mem_re   = 1'b1;
          state_d  = ST_DATA;
        end else begin
          state_d = ST_WB;
        end
      end
      ST_OPND2: begin
        ea_d = {hi_q, mem_rdata};
        if (kind_reads(dec_q.kind)) begin
          mem_addr = {hi_q, mem_rdata};
          mem_re   = 1'b1;
          state_d  = ST_DATA;
        end else begin
          state_d = ST_WB;
        end
      end
      ST_DATA: begin
        opnd_d  = mem_rdata;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        a_d = alu_a;
        c_d = alu_c;
        if (dec_q.kind == K_STOP) begin
          halt_d  = 1'b1;
          state_d = ST_HALT;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_WB: begin
        mem_addr  = ea_q;
        mem_we    = 1'b1;
        mem_wdata = (dec_q.kind == K_STA) ? a_q : b_q;
        state_d   = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      pc_q    <= start_addr;
      a_q     <= '0;
      b_q     <= b_preset;
      c_q     <= 1'b0;
      dec_q   <= '0;
      hi_q    <= '0;
      opnd_q  <= '0;
      ea_q    <= '0;
      halt_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      a_q     <= a_d;
      b_q     <= b_q;
      c_q     <= c_d;
      dec_q   <= dec_d;
      hi_q    <= hi_d;
      opnd_q  <= opnd_d;
      ea_q    <= ea_d;
      halt_q  <= halt_d;
      ill_q   <= ill_d;
    end
  end

  assign halt    = halt_q;
  assign illegal = ill_q;
  assign acc_a   = a_q;
  assign acc_b   = b_q;
  assign pc      = pc_q;
  assign carry   = c_q;

  // R7: a fetch cycle advances the program counter by exactly one.
  assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |=> (pc_q == $past(pc_q) + PC_STEP));

  // R8: a halted core holds its halt and issues no memory traffic.
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);
  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> (!mem_re && !mem_we));

  // R9: the illegal flag never stands without halt.
  assert_illegal_halts_R9: assert property (@(posedge clk) disable iff (rst)
    ill_q |-> halt_q);

  // R6: carry moves only on the edge that ends an add's execute cycle.
  assert_carry_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(state_q == ST_EXEC && dec_q.kind == K_ADD) |=> $stable(c_q));

  // R10: read and write strobes are exclusive.
  assert_rw_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

endmodule

// File: tb/acc8_core_test.sv
`timescale 1ns/1ps
module acc8_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] start_addr = 16'h0;
  logic [7:0]  b_preset = 8'h0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata = 8'h0;
  logic        halt, illegal;
  logic [7:0]  acc_a, acc_b;
  logic [15:0] pc;
  logic        carry;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  acc8_core uut (
    .clk(clk), .rst(rst), .start_addr(start_addr), .b_preset(b_preset),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .halt(halt), .illegal(illegal),
    .acc_a(acc_a), .acc_b(acc_b), .pc(pc), .carry(carry)
  );

  // Memory seen by the core, and the reference model's own copy.
  logic [7:0] mem  [logic [15:0]];
  logic [7:0] rmem [logic [15:0]];
  logic [15:0] cur;

  function automatic logic [7:0] rdm(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] rrm(logic [15:0] a);
    return rmem.exists(a) ? rmem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= rdm(mem_addr);
  end

  // Instruction-level reference state.
  logic [7:0]  r_a, r_b;
  logic        r_c;
  logic [15:0] r_pc;
  bit          r_halt, r_ill, quiet_mon;

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req,  "acc_a",   {8'h0, acc_a}, {8'h0, r_a});
    check("R6", "carry",   {15'h0, carry}, {15'h0, r_c});
    check("R7", "pc",      pc, r_pc);
    check("R8", "halt",    {15'h0, halt}, {15'h0, r_halt});
    check("R9", "illegal", {15'h0, illegal}, {15'h0, r_ill});
    check("R1", "acc_b",   {8'h0, acc_b}, {8'h0, r_b});
  endtask

  // Every clock once halted: no memory strobes, pc frozen (R8).
  logic [15:0] halt_pc;
  always @(negedge clk) begin
    if (!rst && quiet_mon) begin
      check("R8", "strobes after halt", {14'h0, mem_re, mem_we}, 16'h0);
      check("R8", "pc after halt", pc, halt_pc);
    end
  end

  task automatic ref_step(output int cyc, output string req);
    logic [7:0] op, b1, b2;
    logic [8:0] s;
    op = rrm(r_pc); b1 = rrm(r_pc + 16'd1); b2 = rrm(r_pc + 16'd2);
    case (op)
      8'h87: begin r_a = 8'h00; r_pc += 16'd1; cyc = 3; req = "R2"; end
      8'h42: begin r_a += 8'd1; r_pc += 16'd1; cyc = 3; req = "R2"; end
      8'h3F: begin r_halt = 1; r_pc += 16'd1; cyc = 3; req = "R8"; end
      8'h86: begin r_a = b1; r_pc += 16'd2; cyc = 4; req = "R3"; end
      8'h8B: begin s = {1'b0, r_a} + {1'b0, b1}; {r_c, r_a} = s;
                   r_pc += 16'd2; cyc = 4; req = "R3"; end
      8'h96: begin r_a = rrm({8'h00, b1}); r_pc += 16'd2; cyc = 5; req = "R4"; end
      8'h9B: begin s = {1'b0, r_a} + {1'b0, rrm({8'h00, b1})}; {r_c, r_a} = s;
                   r_pc += 16'd2; cyc = 5; req = "R4"; end
      8'h97: begin rmem[{8'h00, b1}] = r_a; r_pc += 16'd2; cyc = 4; req = "R4"; end
      8'hB6: begin r_a = rrm({b1, b2}); r_pc += 16'd3; cyc = 6; req = "R5"; end
      8'hAB: begin s = {1'b0, r_a} + {1'b0, rrm({b1, b2})}; {r_c, r_a} = s;
                   r_pc += 16'd3; cyc = 6; req = "R5"; end
      8'hF7: begin rmem[{b1, b2}] = r_b; r_pc += 16'd3; cyc = 5; req = "R5"; end
      default: begin r_halt = 1; r_ill = 1; r_pc += 16'd1; cyc = 2; req = "R9"; end
    endcase
  endtask

  task automatic poke(logic [15:0] a, logic [7:0] v);
    mem[a] = v; rmem[a] = v;
  endtask

  task automatic put(logic [7:0] v);
    poke(cur, v); cur += 16'd1;
  endtask

  task automatic prep(logic [15:0] st);
    @(negedge clk);
    quiet_mon = 0;
    rst = 1;
    mem.delete(); rmem.delete();
    cur = st;
  endtask

  task automatic run(logic [15:0] st, logic [7:0] bp);
    int cyc;
    string req;
    start_addr = st; b_preset = bp;
    r_pc = st; r_a = 8'h00; r_b = bp; r_c = 0; r_halt = 0; r_ill = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst = 0;
    for (int i = 0; i < 64 && !r_halt; i++) begin
      ref_step(cyc, req);
      repeat (cyc) @(posedge clk);
      @(negedge clk);
      compare_all(req);
    end
    halt_pc = pc;
    quiet_mon = 1;
    repeat (12) @(negedge clk);
    compare_all("R8");
    foreach (rmem[k]) check("R10", "memory byte", {8'h0, rdm(k)}, {8'h0, rmem[k]});
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    quiet_mon = 0;
    // Immediate load and add (R3).
    prep(16'h2000);
    put(8'h86); put(8'h12); put(8'h8B); put(8'h15); put(8'h3F);
    run(16'h2000, 8'h11);

    // Direct store then add from page zero, consecutive opcodes (R4, R7).
    prep(16'h2000);
    put(8'h86); put(8'h04); put(8'h97); put(8'h15);
    put(8'h86); put(8'h08); put(8'h9B); put(8'h15); put(8'h3F);
    run(16'h2000, 8'h22);
    check("R4", "page-zero store", {8'h0, rdm(16'h0015)}, 16'h0004);

    // Inherent ops, carry wrap, extended big-endian access, store B (R2, R5, R6).
    prep(16'h0400);
    poke(16'h0015, 8'h77);
    poke(16'h3010, 8'hC3);
    poke(16'h1030, 8'hEE);
    poke(16'h3011, 8'h50);
    put(8'h87); put(8'h42); put(8'h86); put(8'hFF); put(8'h8B); put(8'h01);
    put(8'h42); put(8'h86); put(8'h80); put(8'h96); put(8'h15);
    put(8'hB6); put(8'h30); put(8'h10); put(8'h8B); put(8'h01);
    put(8'hAB); put(8'h30); put(8'h11); put(8'h87);
    put(8'hF7); put(8'h40); put(8'h22); put(8'h3F);
    run(16'h0400, 8'h5A);
    check("R5", "extended store of B", {8'h0, rdm(16'h4022)}, 16'h005A);
    check("R6", "carry after final clear", {15'h0, carry}, 16'h0001);

    // Unknown opcode after an increment (R9).
    prep(16'h0100);
    put(8'h42); put(8'h00); put(8'h42);
    run(16'h0100, 8'h33);
    check("R9", "illegal pc", pc, 16'h0102);

    // Store rewrites the very next opcode into the stop code (R10, R8).
    prep(16'h0200);
    put(8'hF7); put(8'h02); put(8'h03); put(8'h00);
    run(16'h0200, 8'h3F);
    check("R8", "halt from rewritten opcode", {14'h0, halt, illegal}, 16'h0002);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule